// File: doc/BRIEF.md
# Dual Retriggerable Pulse Generator

This block produces timed pulses on two channels that work on their own. Each channel watches three synchronous control lines. The first is a falling-edge trigger line, the second a rising-edge trigger line, and the third an active-low clear line. A transition counts as a trigger only when the other two lines are at their enabling levels.

A valid trigger loads a down-counter with the channel's programmed width, given in clock cycles. The true output stays high while that counter is non-zero, and the inverted output follows it. A trigger that arrives during a pulse reloads the counter, so the pulse is stretched. A train of triggers that comes faster than the width keeps the output high without a break.

Pulling clear low drops the output in the same cycle and discards the pulse. While clear is low, every trigger is refused. A rising edge on clear is itself a trigger when the falling-edge line is low and the rising-edge line is high.

All inputs must already be synchronous to `clk`.

Top module: `dual_retrig_pulse`

## Requirements
- R1: A 1-to-0 transition on `trigFall[i]` is a valid trigger only if `trigRise[i]` is 1 and `clearN[i]` is 1 in that cycle.
- R2: A 0-to-1 transition on `trigRise[i]` is a valid trigger only if `trigFall[i]` is 0 and `clearN[i]` is 1 in that cycle.
- R3: A 0-to-1 transition on `clearN[i]` is a valid trigger if `trigFall[i]` is 0 and `trigRise[i]` is 1 in that cycle.
- R4: While `clearN[i]` is 0, `pulseQ[i]` is 0 in that same cycle and every trigger is ignored. A pulse cut short by clear does not resume when clear returns high without a trigger.
- R5: After a valid trigger, `pulseQ[i]` rises on the next clock edge and stays high for exactly W cycles. W is `widthCycles[i*CNT_W +: CNT_W]`, sampled in the cycle of the trigger.
- R6: A valid trigger during a pulse restarts the timing, so the output stays high for W cycles after the most recent trigger. A trigger period shorter than W holds the output high continuously.
- R7: `pulseQn[i]` is always the inverse of `pulseQ[i]`.
- R8: A width of 0 produces no pulse.
- R9: Steady input levels, and transitions whose gating conditions are not met, produce no pulse.
- R10: The channels are independent, and activity on one never changes the other's outputs.
- R11: During reset and right after it, every `pulseQ` is 0. Input levels held through reset are not taken as edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trigFall | input | NUM_CH | Falling-edge trigger line, one bit per channel |
| trigRise | input | NUM_CH | Rising-edge trigger line, one bit per channel |
| clearN | input | NUM_CH | Active-low clear, one bit per channel |
| widthCycles | input | NUM_CH*CNT_W | Pulse width in cycles, one CNT_W slice per channel |
| pulseQ | output | NUM_CH | True pulse output |
| pulseQn | output | NUM_CH | Inverted pulse output |

## Verification
The checker tests, on every cycle, that:
- clear forces the output low;
- the two outputs stay complementary;
- every rising output edge is preceded by a valid trigger;
- a valid trigger with a non-zero width raises or holds the output;
- a zero-width trigger leaves an idle output low.

The exact length of a pulse, the way retriggers stretch it, the full gating truth table over all input states and toggles, and independence between channels can only be shown by the bench's scenarios. The bench measures these against widths and trigger times that it computes itself.

// File: rtl/dual_pulse_pkg.sv
package dual_pulse_pkg;
  // Strobes from the per-channel control to the counter datapath.
  typedef struct packed {
    logic load;   // valid trigger seen this cycle: reload width
    logic flush;  // clear active: empty counter, gate output
  } pulseStrobe_t;
endpackage

// File: rtl/pulse_ctrl.sv
module pulse_ctrl
  import dual_pulse_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fallIn,
  input  logic         riseIn,
  input  logic         clearN,
  output pulseStrobe_t strobe
);
  logic prevFall, prevRise, prevClr;
  logic fallEdge, riseEdge, clrEdge, trigHit;

  // During reset the history tracks the live inputs, so levels held through
  // reset never look like an edge afterwards.
  always_ff @(posedge clk) begin
    prevFall <= fallIn;
    prevRise <= riseIn;
    prevClr  <= clearN;
  end

  always_comb begin
    fallEdge = prevFall & ~fallIn;
    riseEdge = ~prevRise & riseIn;
    clrEdge  = ~prevClr & clearN;
    trigHit  = clearN & ((fallEdge & riseIn) |
                         (riseEdge & ~fallIn) |
                         (clrEdge & ~fallIn & riseIn));
    strobe.load  = trigHit & rst_n;
    strobe.flush = ~clearN | ~rst_n;
  end
endmodule

// File: rtl/pulse_datapath.sv
module pulse_datapath
  import dual_pulse_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pulseStrobe_t     strobe,
  input  logic [CNT_W-1:0] width,
  output logic             pulseOut
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.flush) begin
      remain <= ZERO;
    end else if (strobe.load) begin
      remain <= width;
    end else if (remain != ZERO) begin
      remain <= remain - ONE;
    end
  end

  // Clear gates the output combinationally so it drops in the same cycle.
  assign pulseOut = (remain != ZERO) & ~strobe.flush;
endmodule

// File: rtl/dual_retrig_pulse.sv
module dual_retrig_pulse
  import dual_pulse_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       trigFall,
  input  logic [NUM_CH-1:0]       trigRise,
  input  logic [NUM_CH-1:0]       clearN,
  input  logic [NUM_CH*CNT_W-1:0] widthCycles,
  output logic [NUM_CH-1:0]       pulseQ,
  output logic [NUM_CH-1:0]       pulseQn
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pulseStrobe_t chStrobe;
    logic         chPulse;

    pulse_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .fallIn (trigFall[ch]),
      .riseIn (trigRise[ch]),
      .clearN (clearN[ch]),
      .strobe (chStrobe)
    );

    pulse_datapath #(.CNT_W(CNT_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (chStrobe),
      .width    (widthCycles[ch*CNT_W +: CNT_W]),
      .pulseOut (chPulse)
    );

    assign pulseQ[ch]  = chPulse;
    assign pulseQn[ch] = ~chPulse;
  end
endmodule

// File: rtl/dual_pulse_chk.sv
module dual_pulse_chk #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       trigFall,
  input logic [NUM_CH-1:0]       trigRise,
  input logic [NUM_CH-1:0]       clearN,
  input logic [NUM_CH*CNT_W-1:0] widthCycles,
  input logic [NUM_CH-1:0]       pulseQ,
  input logic [NUM_CH-1:0]       pulseQn
);
  logic [NUM_CH-1:0] seenFall, seenRise, seenClr, validTrig;

  always_ff @(posedge clk) begin
    seenFall <= trigFall;
    seenRise <= trigRise;
    seenClr  <= clearN;
  end

  // Trigger rules restated from the port-level requirements (R1, R2, R3).
  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      validTrig[i] = rst_n && clearN[i] &&
        ((seenFall[i] && !trigFall[i] && trigRise[i]) ||
         (!seenRise[i] && trigRise[i] && !trigFall[i]) ||
         (!seenClr[i] && !trigFall[i] && trigRise[i]));
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    a_r4_clear_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      !clearN[i] |-> !pulseQ[i]);

    a_r7_outputs_complement: assert property (@(posedge clk) disable iff (!rst_n)
      pulseQn[i] == ~pulseQ[i]);

    a_r5_rise_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pulseQ[i]) |-> $past(validTrig[i]));

    a_r6_trigger_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      (validTrig[i] && widthCycles[i*CNT_W +: CNT_W] != '0 && clearN[i])
        |=> (pulseQ[i] || !clearN[i]));

    a_r8_zero_width_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (validTrig[i] && widthCycles[i*CNT_W +: CNT_W] == '0)
        |=> !pulseQ[i]);
  end
endmodule

bind dual_retrig_pulse dual_pulse_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trigFall(trigFall), .trigRise(trigRise),
  .clearN(clearN), .widthCycles(widthCycles), .pulseQ(pulseQ), .pulseQn(pulseQn)
);

// File: tb/dual_retrig_pulse_tb.sv
module dual_retrig_pulse_tb;
  localparam int NCH = 2;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] aIn = '1;
  logic [NCH-1:0] bIn = '0;
  logic [NCH-1:0] cIn = '1;
  logic [NCH*CW-1:0] widthBus = '0;
  logic [NCH-1:0] qOut, qnOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dual_retrig_pulse #(.NUM_CH(NCH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .trigFall(aIn), .trigRise(bIn), .clearN(cIn),
    .widthCycles(widthBus), .pulseQ(qOut), .pulseQn(qnOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input int ch, input bit a, input bit b, input bit c);
    @(negedge clk);
    aIn[ch] = a; bIn[ch] = b; cIn[ch] = c;
  endtask

  task automatic setWidth(input int ch, input int w);
    widthBus[ch*CW +: CW] = CW'(w);
  endtask

  // Samples from the next negedge on; counts consecutive high samples.
  task automatic measure(input int ch, output int len);
    len = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      if (qOut[ch]) len++;
      else break;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int len;
    // R11: reset state, inputs held with levels that would look like edges
    repeat (3) @(negedge clk);
    #1;
    for (int ch = 0; ch < NCH; ch++) begin
      check(qOut[ch] == 1'b0, "R11 reset q", qOut[ch], 0);
      check(qnOut[ch] == 1'b1, "R7 reset qn", qnOut[ch], 1);
    end
    @(negedge clk);
    aIn = '0; bIn = '1;   // set during reset: must not be seen as edges
    @(negedge clk);
    rst_n = 1'b1;
    settle(3);
    for (int ch = 0; ch < NCH; ch++)
      check(qOut[ch] == 1'b0, "R11 no edge across reset", qOut[ch], 0);

    // R1 R2 R3 R5 R8: width sweep for each trigger kind and channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int kind = 0; kind < 3; kind++) begin
        for (int w = 0; w < 6; w++) begin
          setWidth(ch, w);
          case (kind)
            0: drive(ch, 1, 1, 1);
            1: drive(ch, 0, 0, 1);
            default: drive(ch, 0, 1, 0);
          endcase
          settle(8);
          check(qOut[ch] == 1'b0, "R9 idle before trigger", qOut[ch], 0);
          case (kind)
            0: drive(ch, 0, 1, 1);   // R1 falling A
            1: drive(ch, 0, 1, 1);   // R2 rising B
            default: drive(ch, 0, 1, 1); // R3 rising clear
          endcase
          measure(ch, len);
          check(len == w, (w == 0) ? "R8 zero width" : "R5 pulse length", len, w);
          check(qOut[1-ch] == 1'b0, "R10 other channel quiet", qOut[1-ch], 0);
        end
      end
    end

    // R9 R1 R2 R3 R4: gating sweep over every start state and single toggle
    setWidth(0, 3);
    for (int s = 0; s < 8; s++) begin
      for (int t = 0; t < 3; t++) begin
        bit a0, b0, c0, a1, b1, c1, exp;
        a0 = s[2]; b0 = s[1]; c0 = s[0];
        a1 = (t == 0) ? ~a0 : a0;
        b1 = (t == 1) ? ~b0 : b0;
        c1 = (t == 2) ? ~c0 : c0;
        exp = c1 & ((a0 & ~a1 & b1) | (~b0 & b1 & ~a1) | (~c0 & c1 & ~a1 & b1));
        drive(0, a0, b0, c0);
        settle(8);
        drive(0, a1, b1, c1);
        @(negedge clk); #1;
        check(qOut[0] == exp, "R9 gating table", qOut[0], exp);
        check(qnOut[0] == ~qOut[0], "R7 complement", qnOut[0], ~qOut[0]);
      end
    end

    // R6: retrigger train on channel 1, then tail of W after the last trigger
    begin
      int lastTrig = -100;
      bit bLvl = 1'b0;
      bit exp;
      setWidth(1, 6);
      drive(1, 0, 0, 1);
      settle(8);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk); #1;
        exp = (k - lastTrig >= 1) && (k - lastTrig <= 6);
        check(qOut[1] == exp, "R6 retrigger hold", qOut[1], exp);
        if (k < 24 && (k % 2) == 0) begin
          bLvl = ~bLvl;
          if (bLvl) lastTrig = k;
          bIn[1] = bLvl;
        end
      end
    end

    // R4: clear cuts the pulse at once and blocks triggers
    setWidth(0, 10);
    drive(0, 1, 1, 1);
    settle(12);
    drive(0, 0, 1, 1);
    settle(3);
    check(qOut[0] == 1'b1, "R5 pulse running", qOut[0], 1);
    @(negedge clk);
    cIn[0] = 1'b0;
    #1;
    check(qOut[0] == 1'b0, "R4 clear immediate", qOut[0], 0);
    drive(0, 1, 1, 0);
    drive(0, 0, 1, 0);   // falling A while clear low
    drive(0, 0, 0, 0);
    drive(0, 0, 1, 0);   // rising B while clear low
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      check(qOut[0] == 1'b0, "R4 triggers ignored", qOut[0], 0);
    end
    drive(0, 1, 1, 0);
    drive(0, 1, 1, 1);   // release with A high: no trigger
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      check(qOut[0] == 1'b0, "R4 no resume", qOut[0], 0);
    end
    drive(0, 0, 1, 0);
    drive(0, 0, 1, 1);   // R3 rising clear with A low, B high
    measure(0, len);
    check(len == 10, "R3 clear edge pulse", len, 10);

    // R10: both channels fired together with different widths
    setWidth(0, 3); setWidth(1, 7);
    @(negedge clk);
    aIn = '1; bIn = '1; cIn = '1;
    settle(12);
    begin
      int len0 = 0, len1 = 0;
      @(negedge clk);
      aIn = '0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk); #1;
        if (qOut[0]) len0++;
        if (qOut[1]) len1++;
      end
      check(len0 == 3, "R10 channel 0 width", len0, 3);
      check(len1 == 7, "R10 channel 1 width", len1, 7);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule